// File: doc/BRIEF.md
# Word-Rotating Tweak and Block Conditioning Unit

This block prepares a single 128-bit state block for a compact authenticated-encryption mode that combines a feedback cipher path with a chained MAC. A caller presents a block, a function code and, for padding, a byte length. The caller then pulses `start_i`. The block returns the conditioned block on `result_o` and marks completion with a one-cycle `done_o` pulse. The result stays on `result_o` until the next accepted start.

There are five tweak maps. Each is a linear map built only from whole-word moves and word XORs. The block is treated as four 32-bit words (A, B, C, D), with A in bits [127:96]. One step turns it into (B, C, D, A xor B). Each map repeats this step a fixed number of times, one step per clock. There are three single-cycle functions: one-zero padding of a partial block, forcing the top bit to 0, and forcing the top bit to 1.

The controller is a two-state machine. In `S_IDLE`, a start with a tweak code takes transition `T_LOAD`: the input block is latched, the repeat counter is loaded and the machine enters `S_STEP`. A start with a single-cycle code takes `T_DIRECT`: it writes the result, pulses done and stays in `S_IDLE`. In `S_STEP` the machine takes `T_ITER` and applies one step per clock. When the counter reaches its last step it takes `T_FINISH` back to `S_IDLE`, and done is raised on the following cycle.

Top module: `tweak_unit`

## Requirements
- R1: A synchronous active-high reset clears `busy_o`, `done_o` and `result_o` to zero.
- R2: A tweak step maps words (A,B,C,D), with A = bits [127:96] and D = bits [31:0], to (B,C,D,A xor B).
- R3: Function codes 0,1,2,3,4 apply the step 8,1,2,1,4 times respectively. `done_o` is high in the (N+1)-th cycle after the clock edge that samples `start_i`, where N is the step count.
- R4: Code 5 pads. `len_i` gives the number of valid bytes (0..16), left-aligned from bit 127. For a length L below 16, bytes 0..L-1 counted from the top pass through, byte L becomes 0x80, and every lower byte becomes zero whatever its input.
- R5: Padding with `len_i` = 16 returns the input block unchanged.
- R6: Padding with `len_i` = 0 returns a block whose only set bit is bit 127.
- R7: Code 6 clears bit 127 and code 7 sets bit 127. All other bits pass unchanged.
- R8: Padding and bit forcing raise `done_o` in the first cycle after the edge that samples `start_i`.
- R9: `start_i` is ignored while `busy_o` is high. The running tweak's result and completion cycle are unaffected.
- R10: `result_o` holds its value from completion until the next accepted start.
- R11: `done_o` is a single-cycle pulse per accepted start, and `busy_o` is low whenever `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 3 | Function code (0..4 tweaks, 5 pad, 6 clear top, 7 set top) |
| len_i | input | 5 | Valid byte count for padding (0..16) |
| data_i | input | 128 | Input block |
| result_o | output | 128 | Conditioned block |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while a tweak is stepping |

## Verification
Two events can land in the same cycle: a completion pulse and a new start. The first case is a start issued in the cycle where `done_o` is high, which the machine must accept from `S_IDLE`. The second is a start issued during the last `S_STEP` cycle, which must be dropped. Both are provoked by driving `start_i` at exactly those cycles, following ops of different step counts. They are judged by the completion cycle and the result of each operation, compared with a bench model that repeats the word step or builds the padded block byte by byte.

// File: rtl/tweak_pkg.sv
package tweak_pkg;
    localparam int BLK_W   = 128;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = BLK_W / WORD_W;
    localparam int NBYTES  = BLK_W / 8;
    localparam int LEN_W   = $clog2(NBYTES + 1);

    localparam int REP_F1  = 8;
    localparam int REP_F2  = 1;
    localparam int REP_G1  = 2;
    localparam int REP_G2  = 1;
    localparam int REP_H   = 4;
    localparam int REP_MAX = 8;
    localparam int CNT_W   = $clog2(REP_MAX + 1);

    typedef enum logic [2:0] {
        OP_F1   = 3'd0,
        OP_F2   = 3'd1,
        OP_G1   = 3'd2,
        OP_G2   = 3'd3,
        OP_H    = 3'd4,
        OP_PAD  = 3'd5,
        OP_CLR  = 3'd6,
        OP_SET  = 3'd7
    } op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_STEP = 1'b1
    } state_e;

    function automatic logic [CNT_W-1:0] rep_count(input op_e op);
        unique case (op)
            OP_F1:   rep_count = CNT_W'(REP_F1);
            OP_F2:   rep_count = CNT_W'(REP_F2);
            OP_G1:   rep_count = CNT_W'(REP_G1);
            OP_G2:   rep_count = CNT_W'(REP_G2);
            OP_H:    rep_count = CNT_W'(REP_H);
            default: rep_count = '0;
        endcase
    endfunction

    function automatic logic is_tweak(input op_e op);
        is_tweak = (op == OP_F1) || (op == OP_F2) || (op == OP_G1) ||
                   (op == OP_G2) || (op == OP_H);
    endfunction
endpackage

// File: rtl/tweak_step.sv
module tweak_step #(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32
) (
    input  logic [BLK_W-1:0] blk_i,
    output logic [BLK_W-1:0] blk_o
);
    localparam int NW = BLK_W / WORD_W;

    // word k counts from the most significant end
    for (genvar k = 0; k < NW - 1; k++) begin : g_move
        assign blk_o[BLK_W-1-k*WORD_W -: WORD_W] = blk_i[BLK_W-1-(k+1)*WORD_W -: WORD_W];
    end
    assign blk_o[WORD_W-1:0] = blk_i[BLK_W-1 -: WORD_W] ^ blk_i[BLK_W-1-WORD_W -: WORD_W];
endmodule

// File: rtl/tweak_pad.sv
module tweak_pad #(
    parameter int BLK_W = 128,
    parameter int LEN_W = 5
) (
    input  logic [BLK_W-1:0] blk_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [BLK_W-1:0] blk_o
);
    localparam int NB = BLK_W / 8;

    // byte b counts from the most significant end
    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic keep, mark;
        assign keep = (LEN_W'(b) < len_i);
        assign mark = (LEN_W'(b) == len_i);
        assign blk_o[BLK_W-1-8*b -: 8] = keep ? blk_i[BLK_W-1-8*b -: 8] :
                                         mark ? 8'h80 : 8'h00;
    end

    // R6: an empty input yields the marker bit alone at the top
    always_comb begin
        if (len_i == '0) begin
            p_empty_marker_r6: assert (blk_o == {1'b1, {(BLK_W-1){1'b0}}});
        end
    end
endmodule

// File: rtl/tweak_ctrl.sv
module tweak_ctrl
    import tweak_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  op_e  op_i,
    output logic load_o,
    output logic step_o,
    output logic direct_o,
    output logic done_o,
    output logic busy_o
);
    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // next state and controls
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        done_d   = 1'b0;
        load_o   = 1'b0;
        step_o   = 1'b0;
        direct_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (is_tweak(op_i)) begin
                        load_o  = 1'b1;             // T_LOAD
                        cnt_d   = rep_count(op_i);
                        state_d = S_STEP;
                    end else begin
                        direct_o = 1'b1;            // T_DIRECT
                        done_d   = 1'b1;
                    end
                end
            end
            S_STEP: begin
                step_o = 1'b1;                      // T_ITER
                cnt_d  = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    state_d = S_IDLE;               // T_FINISH
                    done_d  = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign done_o = done_q;
    assign busy_o = (state_q == S_STEP);

    p_count_down_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_STEP && cnt_q > CNT_W'(1)) |=> (state_q == S_STEP && cnt_q == $past(cnt_q) - 1'b1));

    p_done_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o);

    p_busy_no_done_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && cnt_q > CNT_W'(1)) |=> !done_o);

    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (!busy_o && !done_o));
endmodule

// File: rtl/tweak_unit.sv
module tweak_unit
    import tweak_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [BLK_W-1:0]  data_i,
    output logic [BLK_W-1:0]  result_o,
    output logic              done_o,
    output logic              busy_o
);
    op_e              op;
    logic             load, step, direct;
    logic [BLK_W-1:0] res_q, step_blk, pad_blk, direct_blk;

    assign op = op_e'(op_i);

    tweak_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .op_i     (op),
        .load_o   (load),
        .step_o   (step),
        .direct_o (direct),
        .done_o   (done_o),
        .busy_o   (busy_o)
    );

    tweak_step #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_step (
        .blk_i (res_q),
        .blk_o (step_blk)
    );

    tweak_pad #(.BLK_W(BLK_W), .LEN_W(LEN_W)) u_pad (
        .blk_i (data_i),
        .len_i (len_i),
        .blk_o (pad_blk)
    );

    always_comb begin
        unique case (op)
            OP_PAD:  direct_blk = pad_blk;
            OP_CLR:  direct_blk = {1'b0, data_i[BLK_W-2:0]};
            OP_SET:  direct_blk = {1'b1, data_i[BLK_W-2:0]};
            default: direct_blk = data_i;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       res_q <= '0;
        else if (load)   res_q <= data_i;
        else if (step)   res_q <= step_blk;
        else if (direct) res_q <= direct_blk;
    end

    assign result_o = res_q;

    p_word_move_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |=> (res_q[BLK_W-1 -: WORD_W] == $past(res_q[BLK_W-1-WORD_W -: WORD_W]) &&
                    res_q[WORD_W +: WORD_W] == $past(res_q[0 +: WORD_W])));

    p_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && !start_i) |=> $stable(res_q));

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (res_q == '0));
endmodule

// File: tb/tweak_unit_tb_top.sv
module tweak_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [4:0]   len = 5'd0;
    logic [127:0] data = '0;
    logic [127:0] result;
    logic         done, busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    tweak_unit dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .op_i(op), .len_i(len),
        .data_i(data), .result_o(result), .done_o(done), .busy_o(busy)
    );

    function automatic logic [127:0] ref_step(input logic [127:0] x, input int n);
        logic [127:0] y = x;
        for (int i = 0; i < n; i++)
            y = {y[95:0], y[127:96] ^ y[95:64]};
        return y;
    endfunction

    function automatic logic [127:0] ref_pad(input logic [127:0] x, input int l);
        logic [127:0] y = '0;
        for (int b = 0; b < 16; b++) begin
            if (b < l)       y[127-8*b -: 8] = x[127-8*b -: 8];
            else if (b == l) y[127-8*b -: 8] = 8'h80;
        end
        return y;
    endfunction

    function automatic int reps(input int o);
        case (o)
            0: return 8;
            1: return 1;
            2: return 2;
            3: return 1;
            4: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue at a negedge; returns at the negedge where done is seen, with edge count
    task automatic run_op(input int o, input int l, input logic [127:0] d, output int cyc);
        start = 1'b1; op = 3'(o); len = 5'(l); data = d;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            @(posedge clk); @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result == '0 && !done && !busy, "R1 reset state", {result[127:2], done, busy}, '0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_tweaks();
        for (int o = 0; o < 5; o++) begin
            for (int k = 0; k < 3; k++) begin
                logic [127:0] d = (k == 0) ? 128'h00000001_00000002_00000004_00000008 : rnd128();
                int cyc;
                run_op(o, 0, d, cyc);
                check(result == ref_step(d, reps(o)), "R2 R3 tweak result", result, ref_step(d, reps(o)));
                check(cyc == reps(o) + 1, "R3 tweak latency", 128'(cyc), 128'(reps(o) + 1));
                @(negedge clk);
                check(!done, "R11 done single pulse", 128'(done), 0);
            end
        end
    endtask

    task automatic t_pad();
        for (int l = 0; l <= 16; l++) begin
            logic [127:0] d = rnd128();
            int cyc;
            run_op(5, l, d, cyc);
            check(result == ref_pad(d, l), "R4 pad by length", result, ref_pad(d, l));
            check(cyc == 1, "R8 pad latency", 128'(cyc), 1);
            if (l == 16) check(result == d, "R5 full block passes", result, d);
            if (l == 0)  check(result == {1'b1, 127'b0}, "R6 empty pad", result, {1'b1, 127'b0});
            @(negedge clk);
        end
    endtask

    task automatic t_fix();
        for (int k = 0; k < 6; k++) begin
            logic [127:0] d = rnd128();
            int cyc;
            d[127] = k[0];
            run_op(6, 0, d, cyc);
            check(result == {1'b0, d[126:0]} && cyc == 1, "R7 R8 clear top", result, {1'b0, d[126:0]});
            @(negedge clk);
            run_op(7, 0, d, cyc);
            check(result == {1'b1, d[126:0]} && cyc == 1, "R7 R8 set top", result, {1'b1, d[126:0]});
            @(negedge clk);
        end
    endtask

    task automatic t_busy_ignore();
        logic [127:0] d = rnd128();
        int cyc;
        start = 1'b1; op = 3'd0; data = d;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            // stray starts while stepping, including the final step cycle
            start = (cyc == 3 || cyc == 8); op = 3'd5; len = 5'd0; data = rnd128();
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == 9, "R9 latency unaffected by busy start", 128'(cyc), 9);
        check(result == ref_step(d, 8), "R9 result unaffected by busy start", result, ref_step(d, 8));
    endtask

    task automatic t_back_to_back();
        logic [127:0] d1 = rnd128(), d2 = rnd128(), d3 = rnd128();
        int cyc;
        run_op(2, 0, d1, cyc);
        // done is high now: a start in this cycle must be taken
        run_op(7, 0, d2, cyc);
        check(result == {1'b1, d2[126:0]} && cyc == 1, "R11 start in done cycle", result, {1'b1, d2[126:0]});
        run_op(4, 0, d3, cyc);
        check(result == ref_step(d3, 4) && cyc == 5, "R3 start after direct done", result, ref_step(d3, 4));
    endtask

    task automatic t_hold();
        logic [127:0] d = rnd128();
        logic [127:0] r;
        int cyc;
        run_op(1, 0, d, cyc);
        r = result;
        for (int i = 0; i < 6; i++) begin
            op = 3'(i); data = rnd128(); len = 5'(i);
            @(negedge clk);
        end
        check(result == r, "R10 result held", result, r);
    endtask

    task automatic t_reset_busy();
        int cyc;
        start = 1'b1; op = 3'd0; data = rnd128();
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(result == '0 && !busy && !done, "R1 reset while busy", result, '0);
        repeat (10) @(negedge clk);
        check(!done && !busy, "R1 no completion after reset", 128'({done, busy}), 0);
        cyc = 0;
    endtask

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tweaks();
        t_pad();
        t_fix();
        t_busy_ignore();
        t_back_to_back();
        t_hold();
        t_reset_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule